// File: doc/BRIEF.md
# Link Power State Request Controller

This block manages the power state of one serial storage link: active, partial or slumber. Software asks for a state by writing a 4-bit command field in a 32-bit control word. The block turns each accepted command into a request on a PHY-side handshake. When the PHY acknowledges or refuses the request, the block clears the field back to idle. Software can therefore poll the field until it reads zero and then issue the next command. The current link state is always visible on a status output.

An automatic mode can be enabled with a bit in the same word. It watches two outstanding-command vectors: the issued-command slots and the active-tag slots. When both vectors empty while the link is active, the block requests a low-power state without software action. A select bit chooses whether that state is partial or slumber. When either vector becomes non-empty while the link is in a low-power state, the block requests the active state again.

Top module: `lpm_link_ctrl`

## Requirements
- R1: After reset the link state reads active (0), `phy_req_o` is low, and `ctrl_rdata_o` is all zero.
- R2: Command codes are 1h (active), 2h (partial) and 6h (slumber), written in `ctrl_wdata_i[31:28]`. Target and link-state encodings are 0 = active, 1 = partial, 2 = slumber. A write of a valid code whose target differs from the link state, made while no request is pending, raises `phy_req_o` with that target on the next cycle. From that cycle until the request ends, the code reads back in `ctrl_rdata_o[31:28]`. This also applies to 2h and 6h written while the automatic enable is set.
- R3: A one-cycle `phy_ack_i` during a request commits the target to `link_state_o`. On the next cycle the request drops and the field reads 0h.
- R4: A one-cycle `phy_nak_i` during a request leaves `link_state_o` unchanged. On the next cycle the request drops and the field reads 0h.
- R5: A write of the code for the state the link is already in starts no request, and the field stays 0h.
- R6: Writes of 0h and of the reserved codes 3h–5h and 7h–Fh start no request, and the field stays 0h. Bits 25:0 of `ctrl_rdata_o` always read zero.
- R7: While a request is pending, writes leave the field and the target unchanged. Bit 27 (slumber select) and bit 26 (automatic enable) are still updated by every write.
- R8: With bit 26 set and the link active, a transition of both `cmd_issue_i` and `act_tag_i` to all-zero requests partial when bit 27 is 0, or slumber when bit 27 is 1. During that request the field reads 0h.
- R9: Automatic entry fires at most once per interval in which both vectors are empty. After a refused automatic request, no new one starts until a vector has been non-zero again. Vectors that are already empty at reset do not trigger it.
- R10: With the link in partial or slumber, no request pending, and either vector non-zero, the block requests active.
- R11: When an accepted software write and an automatic trigger fall in the same cycle, the software request is issued and the automatic one is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Write data: command in 31:28, slumber select in 27, automatic enable in 26 |
| ctrl_rdata_o | output | 32 | Read-back of command field, select and enable bits |
| cmd_issue_i | input | NUM_SLOTS | Issued-command slot vector |
| act_tag_i | input | NUM_SLOTS | Active-tag slot vector |
| phy_req_o | output | 1 | Transition request to the PHY side, held until ack or nak |
| phy_target_o | output | 2 | Requested link state |
| phy_ack_i | input | 1 | One-cycle accept of the request |
| phy_nak_i | input | 1 | One-cycle refusal of the request |
| link_state_o | output | 2 | Current link state |

## Verification
Two functions can fall in the same cycle: acceptance of a software command, and automatic low-power entry when the slot vectors empty. The bench provokes the collision by clearing the last busy vector on the same edge as it writes a partial command, with slumber selected for automatic entry. The test passes only if the request targets partial, the field reads 2h, and no slumber request follows after the acknowledge. The bench also writes a new command on the edge that carries an acknowledge. There, the write must be dropped while the select and enable bits still change.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LINK_ACTIVE  = 2'd0,
    LINK_PARTIAL = 2'd1,
    LINK_SLUMBER = 2'd2
  } link_state_e;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned CODE_LSB  = 28;
  localparam int unsigned SEL_BIT   = 27;
  localparam int unsigned EN_BIT    = 26;
  localparam int unsigned CTRL_W    = 32;

  localparam logic [CODE_W-1:0] CODE_IDLE    = 4'h0;
  localparam logic [CODE_W-1:0] CODE_ACTIVE  = 4'h1;
  localparam logic [CODE_W-1:0] CODE_PARTIAL = 4'h2;
  localparam logic [CODE_W-1:0] CODE_SLUMBER = 4'h6;
endpackage

// File: rtl/lpm_code_decode.sv
module lpm_code_decode
  import lpm_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output link_state_e       target_o
);
  always_comb begin
    valid_o  = 1'b1;
    target_o = LINK_ACTIVE;
    unique case (code_i)
      CODE_ACTIVE:  target_o = LINK_ACTIVE;
      CODE_PARTIAL: target_o = LINK_PARTIAL;
      CODE_SLUMBER: target_o = LINK_SLUMBER;
      default:      valid_o  = 1'b0; // idle and reserved codes
    endcase
  end
endmodule

// File: rtl/lpm_auto_trigger.sv
module lpm_auto_trigger
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] cmd_issue_i,
  input  logic [NUM_SLOTS-1:0] act_tag_i,
  input  link_state_e          link_i,
  input  logic                 en_i,
  input  logic                 sel_slumber_i,
  input  logic                 idle_i,
  input  logic                 block_i,
  output logic                 wake_o,
  output logic                 sleep_o,
  output link_state_e          target_o
);
  logic slots_empty;
  logic armed_q;
  logic free;

  assign slots_empty = ~(|cmd_issue_i) & ~(|act_tag_i);
  assign free        = idle_i & ~block_i;

  assign wake_o  = free & ~slots_empty & (link_i != LINK_ACTIVE);
  assign sleep_o = free & slots_empty & armed_q & en_i & (link_i == LINK_ACTIVE);

  always_comb begin
    if (wake_o)             target_o = LINK_ACTIVE;
    else if (sel_slumber_i) target_o = LINK_SLUMBER;
    else                    target_o = LINK_PARTIAL;
  end

  // armed once the slots have been busy; spent by one automatic entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           armed_q <= 1'b0;
    else if (!slots_empty) armed_q <= 1'b1;
    else if (sleep_o)      armed_q <= 1'b0;
  end
endmodule

// File: rtl/lpm_req_engine.sv
module lpm_req_engine
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  link_state_e       start_target_i,
  input  logic [CODE_W-1:0] start_code_i,
  input  logic              ack_i,
  input  logic              nak_i,
  output logic              req_o,
  output link_state_e       target_o,
  output logic [CODE_W-1:0] code_o,
  output link_state_e       link_o
);
  logic              req_q;
  link_state_e       target_q;
  link_state_e       link_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      target_q <= LINK_ACTIVE;
      link_q   <= LINK_ACTIVE;
      code_q   <= CODE_IDLE;
    end else if (req_q) begin
      if (ack_i) begin
        link_q <= target_q;
        req_q  <= 1'b0;
        code_q <= CODE_IDLE;
      end else if (nak_i) begin
        req_q  <= 1'b0;
        code_q <= CODE_IDLE;
      end
    end else if (start_i) begin
      req_q    <= 1'b1;
      target_q <= start_target_i;
      code_q   <= start_code_i;
    end
  end

  assign req_o    = req_q;
  assign target_o = target_q;
  assign code_o   = code_q;
  assign link_o   = link_q;
endmodule

// File: rtl/lpm_link_ctrl.sv
module lpm_link_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_we_i,
  input  logic [31:0]          ctrl_wdata_i,
  output logic [31:0]          ctrl_rdata_o,
  input  logic [NUM_SLOTS-1:0] cmd_issue_i,
  input  logic [NUM_SLOTS-1:0] act_tag_i,
  output logic                 phy_req_o,
  output logic [1:0]           phy_target_o,
  input  logic                 phy_ack_i,
  input  logic                 phy_nak_i,
  output logic [1:0]           link_state_o
);
  logic [CODE_W-1:0] wr_code;
  logic              wr_valid;
  link_state_e       wr_target;
  logic              sel_q, en_q;
  logic              busy;
  link_state_e       cur_link, cur_target, auto_target, start_target;
  logic [CODE_W-1:0] cur_code, start_code;
  logic              sw_start, wake, sleep, start;

  assign wr_code = ctrl_wdata_i[CODE_LSB +: CODE_W];

  lpm_code_decode u_decode (
    .code_i   (wr_code),
    .valid_o  (wr_valid),
    .target_o (wr_target)
  );

  assign sw_start = ctrl_we_i & ~busy & wr_valid & (wr_target != cur_link);

  lpm_auto_trigger #(.NUM_SLOTS(NUM_SLOTS)) u_auto (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_issue_i   (cmd_issue_i),
    .act_tag_i     (act_tag_i),
    .link_i        (cur_link),
    .en_i          (en_q),
    .sel_slumber_i (sel_q),
    .idle_i        (~busy),
    .block_i       (sw_start),
    .wake_o        (wake),
    .sleep_o       (sleep),
    .target_o      (auto_target)
  );

  assign start        = sw_start | wake | sleep;
  assign start_target = sw_start ? wr_target : auto_target;
  assign start_code   = sw_start ? wr_code : CODE_IDLE;

  lpm_req_engine u_engine (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .start_target_i (start_target),
    .start_code_i   (start_code),
    .ack_i          (phy_ack_i),
    .nak_i          (phy_nak_i),
    .req_o          (busy),
    .target_o       (cur_target),
    .code_o         (cur_code),
    .link_o         (cur_link)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      sel_q <= ctrl_wdata_i[SEL_BIT];
      en_q  <= ctrl_wdata_i[EN_BIT];
    end
  end

  always_comb begin
    ctrl_rdata_o                       = '0;
    ctrl_rdata_o[CODE_LSB +: CODE_W]   = cur_code;
    ctrl_rdata_o[SEL_BIT]              = sel_q;
    ctrl_rdata_o[EN_BIT]               = en_q;
  end

  assign phy_req_o    = busy;
  assign phy_target_o = cur_target;
  assign link_state_o = cur_link;
endmodule

// File: rtl/lpm_link_ctrl_chk.sv
module lpm_link_ctrl_chk #(
  parameter int unsigned NUM_SLOTS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctrl_we_i,
  input logic [31:0]          ctrl_wdata_i,
  input logic [31:0]          ctrl_rdata_o,
  input logic [NUM_SLOTS-1:0] cmd_issue_i,
  input logic [NUM_SLOTS-1:0] act_tag_i,
  input logic                 phy_req_o,
  input logic [1:0]           phy_target_o,
  input logic                 phy_ack_i,
  input logic                 phy_nak_i,
  input logic [1:0]           link_state_o
);
  logic wr_reserved;
  assign wr_reserved = !(ctrl_wdata_i[31:28] inside {4'h1, 4'h2, 4'h6});

  assert_field_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[31:28] != 4'h0) |-> phy_req_o);

  assert_ack_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && phy_ack_i) |=>
      (!phy_req_o && link_state_o == $past(phy_target_o) && ctrl_rdata_o[31:28] == 4'h0));

  assert_nak_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && phy_nak_i && !phy_ack_i) |=>
      (!phy_req_o && $stable(link_state_o) && ctrl_rdata_o[31:28] == 4'h0));

  assert_no_redundant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> (phy_target_o != link_state_o));

  assert_reserved_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phy_req_o && ctrl_we_i && wr_reserved) |=> (ctrl_rdata_o[31:28] == 4'h0));

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && !phy_ack_i && !phy_nak_i) |=>
      (phy_req_o && $stable(phy_target_o) && $stable(ctrl_rdata_o[31:28])));

  assert_low_bits_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[25:0] == 26'd0);
endmodule

bind lpm_link_ctrl lpm_link_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/lpm_link_ctrl_test.sv
`timescale 1ns/1ps
module lpm_link_ctrl_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [N-1:0]  ci = '0;
  logic [N-1:0]  at = '0;
  logic          ack = 1'b0;
  logic          nak = 1'b0;
  logic [31:0]   rdata;
  logic          req;
  logic [1:0]    tgt;
  logic [1:0]    link;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  lpm_link_ctrl #(.NUM_SLOTS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata), .cmd_issue_i(ci), .act_tag_i(at),
    .phy_req_o(req), .phy_target_o(tgt), .phy_ack_i(ack), .phy_nak_i(nak),
    .link_state_o(link)
  );

  // behavioural reference model
  int m_link, m_req, m_tgt, m_icc, m_asp, m_alpe, m_armed;
  int r_code, r_t;
  bit r_empty, r_fire;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_link = 0; m_req = 0; m_tgt = 0; m_icc = 0;
      m_asp = 0; m_alpe = 0; m_armed = 0;
    end else begin
      r_empty = (ci == 0) && (at == 0);
      r_fire  = 1'b0;
      r_code  = int'(wdata[31:28]);
      r_t     = (r_code == 1) ? 0 : (r_code == 2) ? 1 : (r_code == 6) ? 2 : -1;
      if (m_req != 0) begin
        if (ack) begin m_link = m_tgt; m_req = 0; m_icc = 0; end
        else if (nak) begin m_req = 0; m_icc = 0; end
      end else begin
        if (we && r_t >= 0 && r_t != m_link) begin
          m_req = 1; m_tgt = r_t; m_icc = r_code;
        end else if (!r_empty && m_link != 0) begin
          m_req = 1; m_tgt = 0;
        end else if (r_empty && m_armed != 0 && m_alpe != 0 && m_link == 0) begin
          m_req = 1; m_tgt = (m_asp != 0) ? 2 : 1; r_fire = 1'b1;
        end
      end
      if (!r_empty) m_armed = 1;
      else if (r_fire) m_armed = 0;
      if (we) begin m_asp = int'(wdata[27]); m_alpe = int'(wdata[26]); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model link state", int'(link), m_link);
      chk("R2 model request", int'(req), m_req);
      if (m_req != 0) chk("R2 model target", int'(tgt), m_tgt);
      chk("R6 model readback", int'(rdata), (m_icc << 28) | (m_asp << 27) | (m_alpe << 26));
    end
  end

  function automatic logic [31:0] word(input logic [3:0] code, input logic sel, input logic en);
    return {code, sel, en, 26'd0};
  endfunction

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1'b1; wdata = d;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_nak();
    nak = 1'b1; step(); nak = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk("R1 reset link", int'(link), 0);
    chk("R1 reset req", int'(req), 0);
    chk("R1 reset readback", int'(rdata), 0);

    // same-state request dropped
    wr(word(4'h1, 1'b0, 1'b0));
    chk("R5 same-state req", int'(req), 0);
    chk("R5 same-state field", int'(rdata[31:28]), 0);

    // reserved and idle codes dropped
    foreach (r_codes[i]) begin
      wr(word(r_codes[i], 1'b0, 1'b0));
      chk("R6 reserved req", int'(req), 0);
      chk("R6 reserved field", int'(rdata[31:28]), 0);
    end

    // software partial request
    wr(word(4'h2, 1'b0, 1'b0));
    chk("R2 partial req", int'(req), 1);
    chk("R2 partial target", int'(tgt), 1);
    chk("R2 partial field", int'(rdata[31:28]), 2);
    // write while pending: field held, enable bit updated
    wr(word(4'h6, 1'b0, 1'b1));
    chk("R7 pending target", int'(tgt), 1);
    chk("R7 pending field", int'(rdata[31:28]), 2);
    chk("R7 enable updated", int'(rdata[26]), 1);
    pulse_ack();
    chk("R3 ack link", int'(link), 1);
    chk("R3 ack req", int'(req), 0);
    chk("R3 ack field", int'(rdata[31:28]), 0);

    // refused wake request
    wr(word(4'h1, 1'b0, 1'b1));
    chk("R2 active target", int'(tgt), 0);
    pulse_nak();
    chk("R4 nak link", int'(link), 1);
    chk("R4 nak req", int'(req), 0);
    chk("R4 nak field", int'(rdata[31:28]), 0);
    wr(word(4'h1, 1'b0, 1'b1));
    pulse_ack();
    chk("R3 back to active", int'(link), 0);
    step(3);
    chk("R9 no trigger without transition", int'(req), 0);

    // automatic partial, refused, not retried
    ci = 32'h1; step();
    chk("R8 busy slots no request", int'(req), 0);
    ci = '0; step();
    chk("R8 auto partial req", int'(req), 1);
    chk("R8 auto partial target", int'(tgt), 1);
    chk("R8 auto field idle", int'(rdata[31:28]), 0);
    pulse_nak();
    step(3);
    chk("R9 no retry after nak", int'(req), 0);
    chk("R9 link kept", int'(link), 0);

    // automatic slumber
    wr(word(4'h0, 1'b1, 1'b1));
    chk("R6 idle write with select", int'(req), 0);
    at = 32'h8000_0000; step();
    at = '0; step();
    chk("R8 auto slumber target", int'(tgt), 2);
    pulse_ack();
    chk("R8 slumber link", int'(link), 2);

    // wake on outstanding commands
    ci = 32'h10; step();
    chk("R10 wake req", int'(req), 1);
    chk("R10 wake target", int'(tgt), 0);
    pulse_ack();
    chk("R10 woke link", int'(link), 0);
    ci = '0; step();
    chk("R8 rearmed slumber", int'(tgt), 2);
    pulse_ack();
    at = 32'h2; step();
    chk("R10 wake from tag", int'(tgt), 0);
    // write on the ack edge: dropped, bits still written
    we = 1'b1; wdata = word(4'h2, 1'b1, 1'b0); ack = 1'b1;
    step();
    we = 1'b0; wdata = '0; ack = 1'b0;
    chk("R7 write on ack edge req", int'(req), 0);
    chk("R7 enable cleared on ack edge", int'(rdata[26]), 0);
    chk("R3 link after wake", int'(link), 0);
    wr(word(4'h0, 1'b1, 1'b1));

    // collision: software write and automatic trigger same edge
    at = '0; we = 1'b1; wdata = word(4'h2, 1'b1, 1'b1);
    step();
    we = 1'b0; wdata = '0;
    chk("R11 software wins target", int'(tgt), 1);
    chk("R11 software wins field", int'(rdata[31:28]), 2);
    pulse_ack();
    step(3);
    chk("R11 no auto after software", int'(req), 0);
    chk("R11 link partial", int'(link), 1);

    // low-power code while automatic enable is set
    wr(word(4'h6, 1'b1, 1'b1));
    chk("R2 slumber with enable target", int'(tgt), 2);
    chk("R2 slumber with enable field", int'(rdata[31:28]), 6);
    pulse_ack();
    chk("R3 slumber link", int'(link), 2);
    step(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [3:0] r_codes [0:5] = '{4'h0, 4'h3, 4'h5, 4'h7, 4'hA, 4'hF};
endmodule